// File: doc/BRIEF.md
# Tagged Auto-Increment Memory Load Port

This block is a register-mapped programmed-I/O window through which a host fills a small instruction memory and a separate data memory with a firmware image, one 32-bit word per bus write. A control register sets the start byte offset, enables automatic post-increment of that offset and selects whether the words being written are secure. Once it is set up, the host streams words into a data register. Each access moves the offset forward by one word, so a whole image is loaded with one control write and a run of data writes.

The instruction memory is split into 256-byte blocks. Each block keeps a tag and a secure attribute next to its data. Both are taken from the tag register and the secure flag in effect when a word lands in that block. A host normally writes the tag as the byte offset shifted right by 8 and raises it by one for each further block. A lookup port returns the tag and secure attribute of any block. The data memory has its own control and data registers with the same stepping rules, but it keeps no tag and no secure attribute. Reads of a data register return the word at the current offset and step the offset in the same way as writes.

Top module: `pio_load_port`

## Requirements
- R1: A write to the instruction control register (address 0) loads the byte offset from bits [15:0], auto-increment from bit 16 and the secure flag from bit 17, and clears the overflow flag. A read returns the word-aligned offset in bits [15:0], auto-increment in bit 16, secure in bit 17 and the sticky overflow flag in bit 31. All other bits read as zero.
- R2: A write to the instruction data register (address 2) stores the full 32-bit word at the current offset. Bits [7:0] hold the image byte at the lowest address of the word. A later read at that offset returns the same word.
- R3: With auto-increment set, every data-register access adds 4 to the offset. With it clear, the offset does not change, so repeated writes replace the same word.
- R4: Each instruction data write records the value of the tag register (address 1, bits [15:0], readable at the same address) as the tag of the 256-byte block the word falls in. The block index is the byte offset shifted right by 8.
- R5: Each instruction data write records the current secure flag as the secure attribute of the block the word falls in.
- R6: The data memory uses its own control register (address 3) and data register (address 4). Their fields and stepping are the same as on the instruction side, except that it has no secure bit (bit 17 reads 0) and no tag. Its contents and offset are independent of the instruction side.
- R7: A read of a data register returns the word at the current offset on `bus_rdata` in the cycle after the read strobe. The offset then advances by 4 if auto-increment is set.
- R8: Offset bits [1:0] and the bits above the memory size are ignored on a control write.
- R9: An offset that steps past the last word wraps to zero and sets the sticky overflow flag. Only a write to that memory's control register clears the flag.
- R10: After reset, both control registers, the tag register, `bus_rdata` and every block's tag and secure attribute read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| lk_blk | input | BLK_AW | Block index to look up |
| lk_tag | output | TAG_W | Tag of the looked-up block, one cycle later |
| lk_sec | output | 1 | Secure attribute of the looked-up block, one cycle later |

## Verification
Control and tag writes take effect at the clock edge that samples them, and the next read shows the new offset, flags and tag. Read data is due one edge after the read strobe, and lookup results are due one edge after `lk_blk` changes. The bench drives every strobe at a falling edge and samples at the following falling edge, exactly one rising edge later. Offset stepping, wrap and overflow are observed through control-register reads after each sequence of data accesses. Block metadata is observed through the lookup port right after the word that set it.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int REG_AW    = 3;
  localparam int OFF_W     = 16;
  localparam int INC_BIT   = 16;
  localparam int SEC_BIT   = 17;
  localparam int OVF_BIT   = 31;
  localparam int BLK_BYTES = 256;
  localparam int BLK_WORDS = BLK_BYTES / 4;

  typedef enum logic [REG_AW-1:0] {
    REG_ICTL = 3'd0,
    REG_ITAG = 3'd1,
    REG_IDAT = 3'd2,
    REG_DCTL = 3'd3,
    REG_DDAT = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/pio_offset_ctr.sv
module pio_offset_ctr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_word,
  input  logic          ld_inc,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          inc,
  output logic          ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      inc  <= 1'b0;
      ovf  <= 1'b0;
    end else if (ld) begin
      addr <= ld_word;
      inc  <= ld_inc;
      ovf  <= 1'b0;
    end else if (step && inc) begin
      addr <= addr + 1'b1;
      if (&addr) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/pio_word_ram.sv
module pio_word_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/pio_block_meta.sv
module pio_block_meta #(
  parameter int NBLK  = 4,
  parameter int BW    = 2,
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [BW-1:0]    blk,
  input  logic [TAG_W-1:0] tag,
  input  logic             sec,
  input  logic [BW-1:0]    lk_blk,
  output logic [TAG_W-1:0] lk_tag,
  output logic             lk_sec
);
  logic [TAG_W-1:0] tag_q [NBLK];
  logic [NBLK-1:0]  sec_q;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    always_ff @(posedge clk) begin
      if (rst) begin
        tag_q[g] <= '0;
        sec_q[g] <= 1'b0;
      end else if (we && blk == BW'(g)) begin
        tag_q[g] <= tag;
        sec_q[g] <= sec;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_tag <= '0;
      lk_sec <= 1'b0;
    end else begin
      lk_tag <= tag_q[lk_blk];
      lk_sec <= sec_q[lk_blk];
    end
  end
endmodule

// File: rtl/pio_load_port.sv
module pio_load_port
  import pio_pkg::*;
#(
  parameter int IMEM_BYTES = 1024,
  parameter int DMEM_BYTES = 512,
  parameter int TAG_W      = 16,
  localparam int IAW    = $clog2(IMEM_BYTES / 4),
  localparam int DAW    = $clog2(DMEM_BYTES / 4),
  localparam int NBLK   = IMEM_BYTES / BLK_BYTES,
  localparam int BLK_AW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [BLK_AW-1:0] lk_blk,
  output logic [TAG_W-1:0]  lk_tag,
  output logic              lk_sec
);
  localparam int WPB_AW = $clog2(BLK_WORDS);

  logic wr_ictl, wr_itag, wr_idat, wr_dctl, wr_ddat;
  logic rd_idat, rd_ddat, rd_any;
  logic i_ld, i_step, i_inc, i_ovf;
  logic d_ld, d_step, d_inc, d_ovf;
  logic [IAW-1:0] i_addr;
  logic [DAW-1:0] d_addr;
  logic [31:0] i_q, d_q;
  logic [TAG_W-1:0] itag_q;
  logic isec_q;
  logic [BLK_AW-1:0] wr_blk;
  logic [31:0] ictl_view, dctl_view, reg_view, reg_q;
  logic [REG_AW-1:0] sel_q;

  assign rd_any  = bus_rd && !bus_wr;
  assign wr_ictl = bus_wr && bus_addr == REG_ICTL;
  assign wr_itag = bus_wr && bus_addr == REG_ITAG;
  assign wr_idat = bus_wr && bus_addr == REG_IDAT;
  assign wr_dctl = bus_wr && bus_addr == REG_DCTL;
  assign wr_ddat = bus_wr && bus_addr == REG_DDAT;
  assign rd_idat = rd_any && bus_addr == REG_IDAT;
  assign rd_ddat = rd_any && bus_addr == REG_DDAT;

  assign i_ld   = wr_ictl;
  assign i_step = wr_idat || rd_idat;
  assign d_ld   = wr_dctl;
  assign d_step = wr_ddat || rd_ddat;

  pio_offset_ctr #(.AW(IAW)) u_ictr (
    .clk(clk), .rst(rst), .ld(i_ld), .ld_word(bus_wdata[IAW+1:2]),
    .ld_inc(bus_wdata[INC_BIT]), .step(i_step),
    .addr(i_addr), .inc(i_inc), .ovf(i_ovf)
  );

  pio_offset_ctr #(.AW(DAW)) u_dctr (
    .clk(clk), .rst(rst), .ld(d_ld), .ld_word(bus_wdata[DAW+1:2]),
    .ld_inc(bus_wdata[INC_BIT]), .step(d_step),
    .addr(d_addr), .inc(d_inc), .ovf(d_ovf)
  );

  pio_word_ram #(.AW(IAW), .DW(32)) u_iram (
    .clk(clk), .we(wr_idat), .re(rd_idat), .addr(i_addr),
    .wdata(bus_wdata), .rdata(i_q)
  );

  pio_word_ram #(.AW(DAW), .DW(32)) u_dram (
    .clk(clk), .we(wr_ddat), .re(rd_ddat), .addr(d_addr),
    .wdata(bus_wdata), .rdata(d_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      itag_q <= '0;
      isec_q <= 1'b0;
    end else begin
      if (wr_itag) itag_q <= bus_wdata[TAG_W-1:0];
      if (wr_ictl) isec_q <= bus_wdata[SEC_BIT];
    end
  end

  assign wr_blk = BLK_AW'(i_addr >> WPB_AW);

  pio_block_meta #(.NBLK(NBLK), .BW(BLK_AW), .TAG_W(TAG_W)) u_meta (
    .clk(clk), .rst(rst), .we(wr_idat), .blk(wr_blk), .tag(itag_q),
    .sec(isec_q), .lk_blk(lk_blk), .lk_tag(lk_tag), .lk_sec(lk_sec)
  );

  always_comb begin
    ictl_view = '0;
    ictl_view[IAW+1:2]  = i_addr;
    ictl_view[INC_BIT]  = i_inc;
    ictl_view[SEC_BIT]  = isec_q;
    ictl_view[OVF_BIT]  = i_ovf;
    dctl_view = '0;
    dctl_view[DAW+1:2]  = d_addr;
    dctl_view[INC_BIT]  = d_inc;
    dctl_view[OVF_BIT]  = d_ovf;
    case (bus_addr)
      REG_ICTL: reg_view = ictl_view;
      REG_ITAG: reg_view = 32'(itag_q);
      REG_DCTL: reg_view = dctl_view;
      default:  reg_view = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= REG_ICTL;
      reg_q <= '0;
    end else if (rd_any) begin
      sel_q <= bus_addr;
      reg_q <= reg_view;
    end
  end

  always_comb begin
    case (sel_q)
      REG_IDAT: bus_rdata = i_q;
      REG_DDAT: bus_rdata = d_q;
      default:  bus_rdata = reg_q;
    endcase
  end
endmodule

// File: rtl/pio_load_port_chk.sv
module pio_load_port_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ld,
  input logic          step,
  input logic [AW-1:0] ld_word,
  input logic [AW-1:0] addr,
  input logic          inc,
  input logic          ovf
);
  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld |=> (addr == $past(ld_word)) && !ovf); // R1

  AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && inc && !ld) |=> addr == AW'($past(addr) + 1'b1)); // R3

  AST_NO_INC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (step && !inc && !ld) |=> $stable(addr)); // R3

  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && inc && !ld && (&addr)) |=> ovf && addr == '0); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ld) |=> ovf); // R9
endmodule

bind pio_load_port pio_load_port_chk #(.AW(IAW)) u_chk (
  .clk(clk), .rst(rst), .ld(i_ld), .step(i_step),
  .ld_word(bus_wdata[IAW+1:2]), .addr(i_addr), .inc(i_inc), .ovf(i_ovf)
);

// File: tb/sim_pio_load_port.sv
module sim_pio_load_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0] lk_blk = '0;
  logic [15:0] lk_tag;
  logic lk_sec;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  pio_load_port u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lk_blk(lk_blk), .lk_tag(lk_tag), .lk_sec(lk_sec)
  );

  // entry: {byte offset[15:0], tag[15:0], secure, data[31:0]}
  localparam logic [64:0] VEC [6] = '{
    {16'h0000, 16'h0000, 1'b1, 32'h03020100},
    {16'h00FC, 16'h0010, 1'b0, 32'hDEADBEEF},
    {16'h0104, 16'h0001, 1'b1, 32'h12345678},
    {16'h02A8, 16'h0042, 1'b0, 32'hA5A55A5A},
    {16'h03F0, 16'hFFFF, 1'b1, 32'h0BADF00D},
    {16'h0200, 16'h0002, 1'b1, 32'h76543210}
  };

  function automatic logic [31:0] ctl(input logic [15:0] off, input logic inc,
                                      input logic sec, input logic ovf);
    return {ovf, 13'd0, sec, inc, off};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic look(input logic [1:0] b, output logic [15:0] t, output logic s);
    @(negedge clk);
    lk_blk = b;
    @(negedge clk);
    t = lk_tag; s = lk_sec;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] t;
    logic s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 rdata", bus_rdata, 32'h0);
    rd(3'd0, r); check("R10 ictl", r, 32'h0);
    rd(3'd1, r); check("R10 itag", r, 32'h0);
    rd(3'd3, r); check("R10 dctl", r, 32'h0);
    for (int b = 0; b < 4; b++) begin
      look(2'(b), t, s);
      check("R10 blk tag", 32'(t), 32'h0);
      check("R10 blk sec", 32'(s), 32'h0);
    end

    // table walk: R2 data, R4 tag, R5 secure
    for (int i = 0; i < 6; i++) begin
      logic [15:0] off, tg;
      logic sc;
      logic [31:0] dw;
      {off, tg, sc, dw} = VEC[i];
      wr(3'd0, ctl(off, 1'b0, sc, 1'b0));
      wr(3'd1, 32'(tg));
      wr(3'd2, dw);
      wr(3'd0, ctl(off, 1'b0, sc, 1'b0));
      rd(3'd2, r); check("R2 data readback", r, dw);
      look(off[9:8], t, s);
      check("R4 block tag", 32'(t), 32'(tg));
      check("R5 block secure", 32'(s), 32'(sc));
    end
    rd(3'd1, r); check("R4 tag readback", r, 32'h0002);

    // R3 auto-increment writes
    wr(3'd0, ctl(16'h0100, 1'b1, 1'b0, 1'b0));
    rd(3'd0, r); check("R1 ctl readback", r, ctl(16'h0100, 1'b1, 1'b0, 1'b0));
    wr(3'd1, 32'h7);
    wr(3'd2, 32'h1111_0000);
    wr(3'd2, 32'h2222_0001);
    wr(3'd2, 32'h3333_0002);
    rd(3'd0, r); check("R3 offset after 3 writes", r, ctl(16'h010C, 1'b1, 1'b0, 1'b0));
    look(2'd1, t, s);
    check("R4 block1 retag", 32'(t), 32'h7);
    check("R5 block1 non-secure", 32'(s), 32'h0);

    // R7 auto-increment reads
    wr(3'd0, ctl(16'h0100, 1'b1, 1'b0, 1'b0));
    rd(3'd2, r); check("R7 read word0", r, 32'h1111_0000);
    rd(3'd2, r); check("R7 read word1", r, 32'h2222_0001);
    rd(3'd2, r); check("R7 read word2", r, 32'h3333_0002);
    rd(3'd0, r); check("R7 offset after reads", r, ctl(16'h010C, 1'b1, 1'b0, 1'b0));

    // R3 without auto-increment
    wr(3'd0, ctl(16'h0080, 1'b0, 1'b0, 1'b0));
    wr(3'd2, 32'h1111_1111);
    wr(3'd2, 32'h2222_2222);
    rd(3'd0, r); check("R3 offset held", r, ctl(16'h0080, 1'b0, 1'b0, 1'b0));
    rd(3'd2, r); check("R3 same word replaced", r, 32'h2222_2222);

    // R8 ignored offset bits
    wr(3'd0, ctl(16'h0207, 1'b0, 1'b1, 1'b0));
    rd(3'd0, r); check("R8 low bits dropped", r, ctl(16'h0204, 1'b0, 1'b1, 1'b0));
    wr(3'd2, 32'hCAFE_0001);
    wr(3'd0, ctl(16'h0204, 1'b0, 1'b1, 1'b0));
    rd(3'd2, r); check("R8 aligned store", r, 32'hCAFE_0001);
    wr(3'd0, ctl(16'h0404, 1'b0, 1'b0, 1'b0));
    rd(3'd0, r); check("R8 high bits dropped", r, ctl(16'h0004, 1'b0, 1'b0, 1'b0));

    // R9 wrap and sticky overflow
    wr(3'd0, ctl(16'h03FC, 1'b1, 1'b0, 1'b0));
    wr(3'd2, 32'h0000_0099);
    rd(3'd0, r); check("R9 wrap sets overflow", r, ctl(16'h0000, 1'b1, 1'b0, 1'b1));
    wr(3'd2, 32'h0000_009A);
    rd(3'd0, r); check("R9 overflow sticky", r, ctl(16'h0004, 1'b1, 1'b0, 1'b1));
    wr(3'd0, ctl(16'h0010, 1'b0, 1'b0, 1'b0));
    rd(3'd0, r); check("R9 cleared by ctl write", r, ctl(16'h0010, 1'b0, 1'b0, 1'b0));

    // R6 data memory
    wr(3'd3, ctl(16'h01FC, 1'b1, 1'b1, 1'b0));
    rd(3'd3, r); check("R6 dctl no secure bit", r, ctl(16'h01FC, 1'b1, 1'b0, 1'b0));
    wr(3'd4, 32'h5555_AAAA);
    rd(3'd3, r); check("R6 R9 dmem wrap", r, ctl(16'h0000, 1'b1, 1'b0, 1'b1));
    wr(3'd3, ctl(16'h01FC, 1'b0, 1'b0, 1'b0));
    rd(3'd4, r); check("R6 dmem readback", r, 32'h5555_AAAA);
    rd(3'd0, r); check("R6 imem ctl untouched", r, ctl(16'h0010, 1'b0, 1'b0, 1'b0));
    wr(3'd0, ctl(16'h02A8, 1'b0, 1'b0, 1'b0));
    rd(3'd2, r); check("R6 imem data untouched", r, 32'hA5A5_5A5A);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule